// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the main control sequencer of a multi-cycle processor core. The core has one memory that holds both instructions and data, and one ALU. The core executes a small integer subset: register-register logic and arithmetic (AND, OR, ADD, SUB, SLT), word load, word store, branch-if-equal and unconditional jump. Every instruction passes through a shared fetch state and a shared decode state. After decode, the six-bit opcode from the instruction register selects a class-specific path. The path lasts one to three further states, and each class finishes in its own number of cycles (3 to 5).

In each state the block asserts the datapath controls for that step. These controls are memory read and write enables, the memory address source, the instruction-register load, the destination-register select, the register-file write enable, the write-back source, the two ALU operand selects, the ALU operation class and the PC update controls. The outputs come from registers. They are computed from the state being entered, so every output register is aligned with the state register. The current state is also available at a port. The datapath, the funct-field ALU decoder and exception handling live outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset forces state code 0 (fetch), with the fetch control set, on the next clock edge. This holds from any state.
- R2: Fetch (code 0) asserts mem_rd, ir_ld and pc_we, with addr_sel=0 (PC), srca_sel=0 (PC), srcb_sel=01 (constant 4), alu_op=00 (add) and pc_src=00 (ALU result). The next state is always decode (code 1).
- R3: Decode (code 1) sets srca_sel=0, srcb_sel=11 (immediate shifted left by 2) and alu_op=00, and writes nothing. The next state depends on the opcode: 0x00 goes to execute (6), 0x23 or 0x2B goes to address (2), 0x04 goes to branch (8) and 0x02 goes to jump (9).
- R4: Address (code 2) sets srca_sel=1 (register A), srcb_sel=10 (sign-extended immediate) and alu_op=00. It goes to mem-read (3) for 0x23 and to mem-write (5) for 0x2B.
- R5: A load takes five cycles. Mem-read (3) asserts mem_rd with addr_sel=1. Load-writeback (4) then asserts rf_we with wb_sel=1 (memory data) and dst_sel=0 (rt), and the sequence returns to fetch.
- R6: A store takes four cycles. Mem-write (5) asserts mem_wr with addr_sel=1, and the sequence returns to fetch.
- R7: An R-type instruction takes four cycles. Execute (6) sets srca_sel=1, srcb_sel=00 (register B) and alu_op=10 (funct-decoded). R-writeback (7) then asserts rf_we with dst_sel=1 (rd) and wb_sel=0 (ALU result), and the sequence returns to fetch.
- R8: A branch takes three cycles. Branch (8) sets srca_sel=1, srcb_sel=00, alu_op=01 (subtract), pc_we_cond=1 and pc_src=01 (ALU output register), and the sequence returns to fetch.
- R9: A jump takes three cycles. Jump (9) asserts pc_we with pc_src=10 (jump target), and the sequence returns to fetch.
- R10: Every opcode not listed in R3 goes from decode straight back to fetch, so it takes two cycles.
- R11: Any control not named for a state is 0 in that state. No state asserts both mem_rd and mem_wr. No state asserts both pc_we and pc_we_cond. No state asserts rf_we together with a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU output register |
| ir_ld | output | 1 | Instruction register load |
| dst_sel | output | 1 | Destination register select: 0 = rt, 1 = rd |
| rf_we | output | 1 | Register file write enable |
| wb_sel | output | 1 | Write-back source: 0 = ALU output register, 1 = memory data register |
| srca_sel | output | 1 | ALU operand A source: 0 = PC, 1 = register A |
| srcb_sel | output | 2 | ALU operand B source: 00 = B, 01 = 4, 10 = immediate, 11 = immediate shifted by 2 |
| alu_op | output | 2 | ALU operation class: 00 = add, 01 = subtract, 10 = funct-decoded |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write qualified by the ALU zero flag |
| pc_src | output | 2 | PC source: 00 = ALU result, 01 = ALU output register, 10 = jump target |
| fsm_state | output | 4 | Current state code |

## Verification
A wrong state code or a wrong transition shows at fsm_state on the very next sample. The control vector is registered from the state being entered, so a bad control bit shows in the same cycle as the state it belongs to. A wrong path changes the length of the instruction and the sequence of control vectors between two fetches. A defect in decode dispatch therefore shows within two cycles of the fetch. Every opcode is swept, both from reset and back to back, so a misrouted opcode cannot hide behind a neighbouring one.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  parameter int OPC_W   = 6;
  parameter int STATE_W = 4;
  parameter int SEL_W   = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_LWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } state_t;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel;
    logic             ir_ld;
    logic             dst_sel;
    logic             rf_we;
    logic             wb_sel;
    logic             srca_sel;
    logic [SEL_W-1:0] srcb_sel;
    logic [SEL_W-1:0] alu_op;
    logic             pc_we;
    logic             pc_we_cond;
    logic [SEL_W-1:0] pc_src;
  } ctrl_t;

  localparam logic [SEL_W-1:0] SRCB_REG  = 2'b00;
  localparam logic [SEL_W-1:0] SRCB_FOUR = 2'b01;
  localparam logic [SEL_W-1:0] SRCB_IMM  = 2'b10;
  localparam logic [SEL_W-1:0] SRCB_OFS  = 2'b11;
  localparam logic [SEL_W-1:0] ALU_ADD   = 2'b00;
  localparam logic [SEL_W-1:0] ALU_SUB   = 2'b01;
  localparam logic [SEL_W-1:0] ALU_FUNCT = 2'b10;
  localparam logic [SEL_W-1:0] PCS_ALU   = 2'b00;
  localparam logic [SEL_W-1:0] PCS_OUT   = 2'b01;
  localparam logic [SEL_W-1:0] PCS_JMP   = 2'b10;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_t           cur,
  input  logic [OPC_W-1:0] opcode,
  output state_t           nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_RTYPE:           nxt = ST_EXEC;
          OPC_LOAD, OPC_STORE: nxt = ST_ADDR;
          OPC_BEQ:             nxt = ST_BRANCH;
          OPC_JUMP:            nxt = ST_JUMP;
          default:             nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_MWR : ST_MRD;
      ST_MRD:    nxt = ST_LWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_t st,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (st)
      ST_FETCH: begin
        ctl.mem_rd   = 1'b1;
        ctl.ir_ld    = 1'b1;
        ctl.pc_we    = 1'b1;
        ctl.srcb_sel = SRCB_FOUR;
        ctl.alu_op   = ALU_ADD;
        ctl.pc_src   = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.srcb_sel = SRCB_OFS;
        ctl.alu_op   = ALU_ADD;
      end
      ST_ADDR: begin
        ctl.srca_sel = 1'b1;
        ctl.srcb_sel = SRCB_IMM;
        ctl.alu_op   = ALU_ADD;
      end
      ST_MRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_MWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl.srca_sel = 1'b1;
        ctl.srcb_sel = SRCB_REG;
        ctl.alu_op   = ALU_FUNCT;
      end
      ST_RWB: begin
        ctl.rf_we   = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.srca_sel   = 1'b1;
        ctl.srcb_sel   = SRCB_REG;
        ctl.alu_op     = ALU_SUB;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_src     = PCS_OUT;
      end
      ST_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               addr_sel,
  output logic               ir_ld,
  output logic               dst_sel,
  output logic               rf_we,
  output logic               wb_sel,
  output logic               srca_sel,
  output logic [SEL_W-1:0]   srcb_sel,
  output logic [SEL_W-1:0]   alu_op,
  output logic               pc_we,
  output logic               pc_we_cond,
  output logic [SEL_W-1:0]   pc_src,
  output logic [STATE_W-1:0] fsm_state
);
  state_t state_q, state_nxt, state_d;
  ctrl_t  ctl_d, ctl_q;

  mcc_next_state u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_nxt)
  );

  assign state_d = rst ? ST_FETCH : state_nxt;

  // Controls are decoded from the state being entered so they register alongside it.
  mcc_ctrl_decode u_dec (
    .st  (state_d),
    .ctl (ctl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctl_q   <= ctl_d;
  end

  assign fsm_state  = state_q;
  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign addr_sel   = ctl_q.addr_sel;
  assign ir_ld      = ctl_q.ir_ld;
  assign dst_sel    = ctl_q.dst_sel;
  assign rf_we      = ctl_q.rf_we;
  assign wb_sel     = ctl_q.wb_sel;
  assign srca_sel   = ctl_q.srca_sel;
  assign srcb_sel   = ctl_q.srcb_sel;
  assign alu_op     = ctl_q.alu_op;
  assign pc_we      = ctl_q.pc_we;
  assign pc_we_cond = ctl_q.pc_we_cond;
  assign pc_src     = ctl_q.pc_src;

  AST_RESET_TO_FETCH: assert property (@(posedge clk)
    $past(rst) |-> (state_q == ST_FETCH && ir_ld && mem_rd)); // R1

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2

  AST_DECODE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE) |=> (state_q inside {ST_FETCH, ST_ADDR, ST_EXEC, ST_BRANCH, ST_JUMP})); // R3

  AST_STORE_RETURNS: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (state_q == ST_FETCH)); // R6

  AST_WRITEBACK_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (state_q == ST_FETCH)); // R5

  AST_ONE_MEM_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11

  AST_PC_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && pc_we_cond)); // R11

  AST_RF_NOT_WITH_MEM: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !(mem_rd || mem_wr)); // R11
endmodule

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       mem_rd, mem_wr, addr_sel, ir_ld, dst_sel, rf_we, wb_sel, srca_sel;
  logic [1:0] srcb_sel, alu_op, pc_src;
  logic       pc_we, pc_we_cond;
  logic [3:0] fsm_state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_ld(ir_ld),
    .dst_sel(dst_sel), .rf_we(rf_we), .wb_sel(wb_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .pc_src(pc_src), .fsm_state(fsm_state)
  );

  // Vector order: rd wr addr ir dst we wb srca srcb[2] aluop[2] pcwe pcwc pcsrc[2]
  function automatic logic [15:0] vec_now();
    return {mem_rd, mem_wr, addr_sel, ir_ld, dst_sel, rf_we, wb_sel, srca_sel,
            srcb_sel, alu_op, pc_we, pc_we_cond, pc_src};
  endfunction

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return {8'b1001_0000, 2'b01, 2'b00, 1'b1, 1'b0, 2'b00};
      1: return {8'b0000_0000, 2'b11, 2'b00, 1'b0, 1'b0, 2'b00};
      2: return {8'b0000_0001, 2'b10, 2'b00, 1'b0, 1'b0, 2'b00};
      3: return {8'b1010_0000, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00};
      4: return {8'b0000_0110, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00};
      5: return {8'b0110_0000, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00};
      6: return {8'b0000_0001, 2'b00, 2'b10, 1'b0, 1'b0, 2'b00};
      7: return {8'b0000_1100, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00};
      8: return {8'b0000_0001, 2'b00, 2'b01, 1'b0, 1'b1, 2'b01};
      default: return {8'b0000_0000, 2'b00, 2'b00, 1'b1, 1'b0, 2'b10};
    endcase
  endfunction

  function automatic int exp_next(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'h00) return 6;
        if (op == 6'h23 || op == 6'h2B) return 2;
        if (op == 6'h04) return 8;
        if (op == 6'h02) return 9;
        return 0;
      end
      2: return (op == 6'h2B) ? 5 : 3;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input logic [5:0] op);
    case (op)
      6'h00: return 4;  // R7
      6'h23: return 5;  // R5
      6'h2B: return 4;  // R6
      6'h04: return 3;  // R8
      6'h02: return 3;  // R9
      default: return 2; // R10
    endcase
  endfunction

  function automatic string tag_of(input int s, input logic [5:0] op);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return (op == 6'h3F) ? "R10" : "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_cycle(input int es, input logic [5:0] op);
    string t;
    t = tag_of(es, op);
    chk(fsm_state == es[3:0], t, 32'(fsm_state), 32'(es));
    chk(vec_now() == exp_vec(es), t, 32'(vec_now()), 32'(exp_vec(es)));
    chk(!(mem_rd && mem_wr) && !(pc_we && pc_we_cond) && !(rf_we && (mem_rd || mem_wr)),
        "R11", 32'(vec_now()), 32'(exp_vec(es)));
  endtask

  // Runs one instruction starting with the design in fetch at a negedge.
  task automatic run_instr(input logic [5:0] op);
    int es = 0;
    int len = 0;
    if (op == 6'h3F) check_cycle(0, op); // extra sample for R10 at the top code
    do begin
      es = exp_next(es, op);
      @(posedge clk); @(negedge clk);
      check_cycle(es, op);
      len++;
    end while (es != 0 && len < 8);
    chk(len == exp_len(op), (exp_len(op) == 2) ? "R10" : "R3", 32'(len), 32'(exp_len(op)));
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, 20000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(fsm_state == 4'd0, "R1", 32'(fsm_state), 32'd0);
    chk(vec_now() == exp_vec(0), "R1", 32'(vec_now()), 32'(exp_vec(0)));

    // Sweep every opcode, each from a fresh reset.
    for (int o = 0; o < 64; o++) begin
      @(negedge clk);
      rst = 1'b1;
      opcode = 6'(o);
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      chk(fsm_state == 4'd0 && vec_now() == exp_vec(0), "R1", 32'(fsm_state), 32'd0);
      run_instr(6'(o));
    end

    // Back-to-back sweep with no reset in between.
    for (int o = 63; o >= 0; o--) begin
      opcode = 6'(o);
      run_instr(6'(o));
    end

    // Reset in the middle of a load (state 3) and of an R-type writeback (state 7).
    opcode = 6'h23;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fsm_state == 4'd3, "R5", 32'(fsm_state), 32'd3);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(fsm_state == 4'd0 && vec_now() == exp_vec(0), "R1", 32'(fsm_state), 32'd0);
    opcode = 6'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fsm_state == 4'd7, "R7", 32'(fsm_state), 32'd7);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(fsm_state == 4'd0 && vec_now() == exp_vec(0), "R1", 32'(fsm_state), 32'd0);
    run_instr(6'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule